// File: doc/BRIEF.md
# Management-bus register access sequencer

This block sits on the host side of a serial management bus and turns one register request (device number, register number, direction, write data) into the raw bus accesses that the attached switch needs. Its configuration inputs select one of three ways of reaching the switch. Direct access uses the requested device number as the bus address. Offset access adds the device number to a base address. Tunnelled access goes through a command register and a data register held at the base address. A configuration that fits none of these is refused.

In tunnelled mode the block polls the command register's busy bit. Each polling phase is limited to a fixed number of reads, and the block waits a programmable gap between reads that come back busy.

Upstream there is one valid/ready request channel and one valid/ready response channel. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A response is offered on `rsp_valid` and stays unchanged until `rsp_ready` takes it, so a slow consumer can hold the block off for as long as it likes.

Downstream, `bus_req` asks for one access and stays high, with its fields steady, until the bus side pulses `bus_done`. The bus side returns `bus_rdata` and `bus_err` in that same cycle.

Top module: `smi_seq_ctrl`

## Requirements
- R1: The addressing mode is chosen in priority order. `cfg_dual` high selects offset access. Otherwise a zero `cfg_base` selects direct access. Otherwise `cfg_tunnel_ok` high selects tunnelled access. Any other configuration answers at once with error code 3 and makes no bus access.
- R2: Direct access makes one bus access at address `req_dev`. Offset access makes one bus access at address `cfg_base + req_dev`, taken modulo 32. In both, the register number, direction and write data pass through unchanged.
- R3: A tunnelled read, all at address `cfg_base`, runs in this order: poll register 0 until bit 15 reads 0; write register 0 with the command word; poll again; read register 1. The command word has bit 15 = 1, bit 12 = 1, bits [11:10] = 10 for a read and 01 for a write, the device number in bits [9:5] and the register number in bits [4:0].
- R4: A tunnelled write runs in this order: poll register 0; write `req_wdata` to register 1; write the command word to register 0; poll until busy clears. Only then does the response appear.
- R5: A polling phase makes at most 16 reads of register 0. If the 16th read still shows bit 15 set, the request ends with error code 2.
- R6: After each poll that returns busy, `bus_req` stays low for exactly `cfg_poll_gap`+1 cycles. Between any other consecutive accesses of a request, it does not drop.
- R7: A downstream access returning `bus_err` ends the request with error code 1. No further bus access is made for that request.
- R8: After reset, `req_ready` is high and `rsp_valid` and `bus_req` are low. `req_ready` stays low from acceptance until the response is taken. A response held by `rsp_ready` low keeps its data and error code. A `req_valid` raised while the block is busy starts nothing.
- R9: While `bus_req` is high and `bus_done` is low, the address, register, direction and write data do not change.
- R10: A successful read returns the data of its final read access. A successful request returns error code 0. A write, or a request that fails, returns read data 0.
- R11: The poll counter restarts for each polling phase. The poll after the command write gets its own 16 tries, whatever the first phase used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Dual-device configuration: offset access |
| cfg_base | input | 5 | Base bus address of the switch |
| cfg_tunnel_ok | input | 1 | Switch supports command/data tunnelling |
| cfg_poll_gap | input | 16 | Gap after a busy poll, in cycles minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device number |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 16 | Read result |
| rsp_err | output | 2 | 0 ok, 1 bus error, 2 timeout, 3 bad configuration |
| bus_req | output | 1 | Raw access requested |
| bus_addr | output | 5 | Raw access bus address |
| bus_regno | output | 5 | Raw access register number |
| bus_write | output | 1 | Raw access direction |
| bus_wdata | output | 16 | Raw access write data |
| bus_done | input | 1 | Raw access finished (one-cycle pulse) |
| bus_rdata | input | 16 | Raw access read data, valid with bus_done |
| bus_err | input | 1 | Raw access failed, valid with bus_done |

## Verification
The hardest situations to reach from the ports are the edges of the poll limit. These are a busy bit that clears on exactly the 16th read, and a second polling phase that needs many retries after the first phase has already used many. Either one needs the switch's busy flag to follow a script. The bench's bus model is loaded before each request with separate busy counts for the first phase and for the phase after the command write. It re-arms the second count when it sees the command write. That way 15+1 polls, 16 busy polls, and 10 polls in each phase can each be set up on purpose.

// File: rtl/smi_seq_pkg.sv
package smi_seq_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_OFFSET = 2'd1,
    MODE_TUNNEL = 2'd2,
    MODE_BAD    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_CONFIG  = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    STEP_DIRECT,
    STEP_POLL,
    STEP_CMD,
    STEP_DATA_WR,
    STEP_DATA_RD
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BUS,
    PH_GAP,
    PH_RESP
  } phase_e;

  localparam int STEP_IDX_W   = 2;
  localparam int CMD_BUSY_BIT = 15;
  localparam int CMD_C22_BIT  = 12;
  localparam int CMD_OP_LSB   = 10;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam int REG_CMD_OFS  = 0;
  localparam int REG_DATA_OFS = 1;

endpackage

// File: rtl/smi_mode_sel.sv
module smi_mode_sel
  import smi_seq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          dual,
  input  logic [AW-1:0] base,
  input  logic          tunnel_ok,
  output mode_e         mode
);

  always_comb begin
    if (dual)              mode = MODE_OFFSET;
    else if (base == '0)   mode = MODE_DIRECT;
    else if (tunnel_ok)    mode = MODE_TUNNEL;
    else                   mode = MODE_BAD;
  end

endmodule

// File: rtl/smi_step_map.sv
module smi_step_map
  import smi_seq_pkg::*;
(
  input  mode_e                 mode,
  input  logic                  is_write,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_e                 step,
  output logic                  last
);

  always_comb begin
    step = STEP_DIRECT;
    last = 1'b1;
    if (mode == MODE_TUNNEL) begin
      last = 1'b0;
      unique case (idx)
        2'd0: step = STEP_POLL;
        2'd1: step = is_write ? STEP_DATA_WR : STEP_CMD;
        2'd2: step = is_write ? STEP_CMD : STEP_POLL;
        default: begin
          step = is_write ? STEP_POLL : STEP_DATA_RD;
          last = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/smi_poll_pacer.sv
module smi_poll_pacer #(
  parameter int POLL_MAX = 16,
  parameter int GAP_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             busy_seen,
  input  logic             waiting,
  input  logic [GAP_W-1:0] gap_len,
  output logic             last_poll,
  output logic             gap_over
);

  localparam int PCW = $clog2(POLL_MAX + 1);

  logic [PCW-1:0]   poll_cnt;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt <= '0;
      gap_cnt  <= '0;
    end else if (clear) begin
      poll_cnt <= '0;
      gap_cnt  <= '0;
    end else if (busy_seen) begin
      poll_cnt <= poll_cnt + 1'b1;
      gap_cnt  <= gap_len;
    end else if (waiting && gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign last_poll = (poll_cnt == PCW'(POLL_MAX - 1));
  assign gap_over  = (gap_cnt == '0);

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PCW'(POLL_MAX));

  // R11
  poll_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> poll_cnt == '0);

endmodule

// File: rtl/smi_seq_ctrl.sv
module smi_seq_ctrl
  import smi_seq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int RW       = 5,
  parameter int DW       = 16,
  parameter int GAP_W    = 16,
  parameter int POLL_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic [AW-1:0]    cfg_base,
  input  logic             cfg_tunnel_ok,
  input  logic [GAP_W-1:0] cfg_poll_gap,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_dev,
  input  logic [RW-1:0]    req_reg,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic [1:0]       rsp_err,
  output logic             bus_req,
  output logic [AW-1:0]    bus_addr,
  output logic [RW-1:0]    bus_regno,
  output logic             bus_write,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_done,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err
);

  localparam logic [RW-1:0] CMD_REG  = RW'(REG_CMD_OFS);
  localparam logic [RW-1:0] DATA_REG = RW'(REG_DATA_OFS);

  phase_e                phase;
  logic [STEP_IDX_W-1:0] idx;
  mode_e                 mode_q;
  mode_e                 mode_now;
  logic                  wr_q;
  logic [AW-1:0]         dev_q;
  logic [RW-1:0]         reg_q;
  logic [DW-1:0]         wdata_q;
  logic [AW-1:0]         base_q;
  logic [GAP_W-1:0]      gap_q;
  logic [DW-1:0]         rdata_q;
  err_e                  err_q;

  step_e                 step;
  logic                  step_last;
  logic                  last_poll;
  logic                  gap_over;
  logic                  poll_busy;
  logic                  access_ok;
  logic                  capture;
  logic                  pacer_clear;
  logic                  pacer_busy;
  logic [AW-1:0]         offset_addr;
  logic [DW-1:0]         cmd_word;

  smi_mode_sel #(.AW(AW)) u_mode (
    .dual      (cfg_dual),
    .base      (cfg_base),
    .tunnel_ok (cfg_tunnel_ok),
    .mode      (mode_now)
  );

  smi_step_map u_steps (
    .mode     (mode_q),
    .is_write (wr_q),
    .idx      (idx),
    .step     (step),
    .last     (step_last)
  );

  smi_poll_pacer #(.POLL_MAX(POLL_MAX), .GAP_W(GAP_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pacer_clear),
    .busy_seen (pacer_busy),
    .waiting   (phase == PH_GAP),
    .gap_len   (gap_q),
    .last_poll (last_poll),
    .gap_over  (gap_over)
  );

  // Handshake outputs come straight from the phase register.
  assign req_ready = (phase == PH_IDLE);
  assign rsp_valid = (phase == PH_RESP);
  assign bus_req   = (phase == PH_BUS);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;

  // Outcome of the access finishing this cycle.
  assign poll_busy   = (step == STEP_POLL) && bus_rdata[CMD_BUSY_BIT];
  assign access_ok   = (phase == PH_BUS) && bus_done && !bus_err;
  assign capture     = (step == STEP_DATA_RD) || (step == STEP_DIRECT && !wr_q);
  assign pacer_clear = (req_ready && req_valid) || (access_ok && !poll_busy);
  assign pacer_busy  = access_ok && poll_busy && !last_poll;

  assign offset_addr = base_q + dev_q;

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_BUSY_BIT] = 1'b1;
    cmd_word[CMD_C22_BIT]  = 1'b1;
    cmd_word[CMD_OP_LSB +: 2] = wr_q ? OP_WRITE : OP_READ;
    cmd_word[RW +: AW] = dev_q;
    cmd_word[RW-1:0]   = reg_q;
  end

  always_comb begin
    bus_addr  = base_q;
    bus_regno = CMD_REG;
    bus_write = 1'b0;
    bus_wdata = '0;
    unique case (step)
      STEP_DIRECT: begin
        bus_addr  = (mode_q == MODE_OFFSET) ? offset_addr : dev_q;
        bus_regno = reg_q;
        bus_write = wr_q;
        bus_wdata = wr_q ? wdata_q : '0;
      end
      STEP_CMD: begin
        bus_write = 1'b1;
        bus_wdata = cmd_word;
      end
      STEP_DATA_WR: begin
        bus_regno = DATA_REG;
        bus_write = 1'b1;
        bus_wdata = wdata_q;
      end
      STEP_DATA_RD: bus_regno = DATA_REG;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      mode_q  <= MODE_DIRECT;
      wr_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      base_q  <= '0;
      gap_q   <= '0;
      rdata_q <= '0;
      err_q   <= ERR_NONE;
    end else begin
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          idx     <= '0;
          mode_q  <= mode_now;
          wr_q    <= req_write;
          dev_q   <= req_dev;
          reg_q   <= req_reg;
          wdata_q <= req_wdata;
          base_q  <= cfg_base;
          gap_q   <= cfg_poll_gap;
          rdata_q <= '0;
          if (mode_now == MODE_BAD) begin
            err_q <= ERR_CONFIG;
            phase <= PH_RESP;
          end else begin
            err_q <= ERR_NONE;
            phase <= PH_BUS;
          end
        end
        PH_BUS: if (bus_done) begin
          if (bus_err) begin
            err_q <= ERR_BUS;
            phase <= PH_RESP;
          end else if (poll_busy) begin
            if (last_poll) begin
              err_q <= ERR_TIMEOUT;
              phase <= PH_RESP;
            end else begin
              phase <= PH_GAP;
            end
          end else begin
            if (capture) rdata_q <= bus_rdata;
            if (step_last) phase <= PH_RESP;
            else           idx <= idx + 1'b1;
          end
        end
        PH_GAP: if (gap_over) phase <= PH_BUS;
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_regno)
                             && $stable(bus_write) && $stable(bus_wdata));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R1
  bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cfg_dual == 1'b0 && cfg_base != '0 && !cfg_tunnel_ok
      |=> rsp_valid && rsp_err == 2'd3);

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done && bus_err |=> !bus_req && rsp_valid && rsp_err == 2'd1);

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready && !rsp_valid);

endmodule

// File: tb/smi_seq_ctrl_test.sv
module smi_seq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dual = 1'b0;
  logic [4:0]  cfg_base = '0;
  logic        cfg_tunnel_ok = 1'b0;
  logic [15:0] cfg_poll_gap = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic [1:0]  rsp_err;
  logic        bus_req;
  logic [4:0]  bus_addr;
  logic [4:0]  bus_regno;
  logic        bus_write;
  logic [15:0] bus_wdata;
  logic        bus_done = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic        bus_err = 1'b0;

  always #5 clk = ~clk;

  smi_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_dual(cfg_dual), .cfg_base(cfg_base), .cfg_tunnel_ok(cfg_tunnel_ok),
    .cfg_poll_gap(cfg_poll_gap),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_regno(bus_regno), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bus data pattern: bit 15 always 0, so a plain read never looks busy.
  function automatic logic [15:0] pat(input logic [4:0] a, input logic [4:0] r);
    return {1'b0, r, a, 5'h15};
  endfunction

  // ---------------- bus model ----------------
  logic        log_clr = 1'b0;
  int          pre_busy = 0;
  int          post_busy = 0;
  int          err_at = 0;
  int          busy_left = 0;
  int          log_n = 0;
  int          lat = 0;
  logic [4:0]  log_a [64];
  logic [4:0]  log_r [64];
  logic        log_w [64];
  logic [15:0] log_d [64];

  always @(posedge clk) begin
    bus_done <= 1'b0;
    bus_err  <= 1'b0;
    if (log_clr) begin
      lat       <= 0;
      log_n     <= 0;
      busy_left <= pre_busy;
    end else if (!rst_n || bus_done) begin
      lat <= 0;
    end else if (bus_req) begin
      if (lat == 2) begin
        lat      <= 0;
        bus_done <= 1'b1;
        if (log_n < 64) begin
          log_a[log_n] <= bus_addr;
          log_r[log_n] <= bus_regno;
          log_w[log_n] <= bus_write;
          log_d[log_n] <= bus_wdata;
        end
        log_n   <= log_n + 1;
        bus_err <= (log_n + 1 == err_at);
        if (!bus_write && bus_regno == 5'd0 && busy_left > 0) begin
          bus_rdata <= 16'h8000 | pat(bus_addr, bus_regno);
          busy_left <= busy_left - 1;
        end else begin
          bus_rdata <= pat(bus_addr, bus_regno);
        end
        if (bus_write && bus_regno == 5'd0) busy_left <= post_busy;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // ---------------- request driver ----------------
  logic [1:0]  r_err;
  logic [15:0] r_rdata;
  int          r_lows;
  bit          r_ready_hi;
  bit          r_hung;
  bit          r_hold_bad;

  task automatic run_op(input bit dual, input logic [4:0] base, input bit tun,
                        input bit wr, input logic [4:0] dev, input logic [4:0] rg,
                        input logic [15:0] wd, input int pre, input int post,
                        input int gap, input int eat, input int hold, input bit poke);
    @(negedge clk);
    cfg_dual = dual; cfg_base = base; cfg_tunnel_ok = tun; cfg_poll_gap = 16'(gap);
    pre_busy = pre; post_busy = post; err_at = eat;
    rsp_ready = (hold == 0);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_lows = 0; r_ready_hi = 0; r_hung = 1; r_hold_bad = 0;
    for (int c = 0; c < 20000; c++) begin
      if (rsp_valid) begin r_hung = 0; break; end
      if (!bus_req) r_lows++;
      if (req_ready) r_ready_hi = 1;
      if (poke && c == 1) begin
        req_valid = 1'b1; req_dev = dev ^ 5'h1F; req_write = ~wr;
      end
      if (poke && c == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    r_err = rsp_err; r_rdata = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_err != r_err || rsp_rdata != r_rdata || req_ready)
        r_hold_bad = 1;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        dual;
    logic [4:0]  base;
    logic        tun;
    logic        wr;
    logic [4:0]  dev;
    logic [4:0]  rg;
    logic [15:0] wdata;
    logic [5:0]  pre;
    logic [5:0]  post;
    logic [3:0]  gap;
    logic [1:0]  err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd0,  1'b0, 1'b0, 5'd7,  5'd3,  16'h0000, 6'd0, 6'd0, 4'd0, 2'd0},
    '{1'b0, 5'd0,  1'b0, 1'b1, 5'd2,  5'd9,  16'hA55A, 6'd0, 6'd0, 4'd0, 2'd0},
    '{1'b1, 5'd16, 1'b0, 1'b0, 5'd3,  5'd4,  16'h0000, 6'd0, 6'd0, 4'd0, 2'd0},
    '{1'b1, 5'd8,  1'b1, 1'b1, 5'd1,  5'd31, 16'hBEEF, 6'd0, 6'd0, 4'd0, 2'd0},
    '{1'b1, 5'd30, 1'b0, 1'b0, 5'd5,  5'd6,  16'h0000, 6'd0, 6'd0, 4'd0, 2'd0},
    '{1'b0, 5'd4,  1'b1, 1'b0, 5'd3,  5'd2,  16'h0000, 6'd2, 6'd1, 4'd3, 2'd0},
    '{1'b0, 5'd6,  1'b1, 1'b1, 5'd17, 5'd5,  16'h1234, 6'd0, 6'd3, 4'd1, 2'd0},
    '{1'b0, 5'd2,  1'b0, 1'b0, 5'd1,  5'd1,  16'h0000, 6'd0, 6'd0, 4'd0, 2'd3},
    '{1'b0, 5'd0,  1'b1, 1'b0, 5'd30, 5'd1,  16'h0000, 6'd0, 6'd0, 4'd0, 2'd0}
  };

  // Checks the logged tunnelled sequence against R3/R4 ordering.
  function automatic int seq_mismatch(input logic [4:0] base, input bit wr,
                                      input logic [4:0] dev, input logic [4:0] rg,
                                      input logic [15:0] wd, input int pre, input int post);
    logic [4:0]  er [64];
    logic        ew [64];
    logic [15:0] ed [64];
    logic [15:0] cmd;
    int n = 0;
    int bad = 0;
    cmd = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | (16'(dev) << 5) | 16'(rg);
    for (int i = 0; i <= pre; i++) begin er[n] = 0; ew[n] = 0; ed[n] = 0; n++; end
    if (wr) begin er[n] = 1; ew[n] = 1; ed[n] = wd; n++; end
    er[n] = 0; ew[n] = 1; ed[n] = cmd; n++;
    for (int i = 0; i <= post; i++) begin er[n] = 0; ew[n] = 0; ed[n] = 0; n++; end
    if (!wr) begin er[n] = 1; ew[n] = 0; ed[n] = 0; n++; end
    if (n != log_n) bad++;
    for (int i = 0; i < n && i < log_n; i++) begin
      if (log_a[i] != base || log_r[i] != er[i] || log_w[i] != ew[i]) bad++;
      if (ew[i] && log_d[i] != ed[i]) bad++;
    end
    return bad;
  endfunction

  initial begin : watchdog
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(req_ready == 1'b1, "R8", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(bus_req == 1'b0,   "R8", "bus_req after reset", int'(bus_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VEC[v];
      automatic int kind;          // 0 direct, 1 offset, 2 tunnel, 3 bad (R1)
      automatic logic [4:0] ea;
      automatic int en, el;
      automatic logic [15:0] ed;
      kind = t.dual ? 1 : (t.base == 0) ? 0 : t.tun ? 2 : 3;
      ea = (kind == 1) ? 5'(t.base + t.dev) : t.dev;
      en = (kind == 3) ? 0 : (kind == 2) ? 4 + int'(t.pre) + int'(t.post) : 1;
      el = (kind == 2) ? (int'(t.pre) + int'(t.post)) * (int'(t.gap) + 1) : 0;
      if (t.err != 0 || t.wr) ed = 16'h0;
      else if (kind == 2)     ed = pat(t.base, 5'd1);
      else                    ed = pat(ea, t.rg);
      run_op(t.dual, t.base, t.tun, t.wr, t.dev, t.rg, t.wdata,
             int'(t.pre), int'(t.post), int'(t.gap), 0, 0, 0);
      chk(!r_hung, "R8", $sformatf("vec%0d response", v), int'(r_hung), 0);
      chk(r_err == t.err, "R1", $sformatf("vec%0d error code", v), int'(r_err), int'(t.err));
      chk(r_rdata == ed, "R10", $sformatf("vec%0d read data", v), int'(r_rdata), int'(ed));
      chk(log_n == en, "R1", $sformatf("vec%0d access count", v), log_n, en);
      chk(r_lows == el, "R6", $sformatf("vec%0d idle cycles", v), r_lows, el);
      chk(!r_ready_hi, "R8", $sformatf("vec%0d req_ready low", v), int'(r_ready_hi), 0);
      if (kind == 0 || kind == 1) begin
        // R2 address, register, direction, data
        chk(log_a[0] == ea, "R2", $sformatf("vec%0d bus address", v), int'(log_a[0]), int'(ea));
        chk(log_r[0] == t.rg && log_w[0] == t.wr && (!t.wr || log_d[0] == t.wdata),
            "R2", $sformatf("vec%0d register/dir/data", v), int'(log_r[0]), int'(t.rg));
      end
      if (kind == 2) begin
        automatic int bad = seq_mismatch(t.base, t.wr, t.dev, t.rg, t.wdata,
                                         int'(t.pre), int'(t.post));
        if (t.wr) chk(bad == 0, "R4", $sformatf("vec%0d write sequence", v), bad, 0);
        else      chk(bad == 0, "R3", $sformatf("vec%0d read sequence", v), bad, 0);
      end
    end

    // R5: busy never clears -> 16 polls then timeout
    run_op(0, 5'd4, 1, 0, 5'd3, 5'd2, 16'h0, 40, 0, 0, 0, 0, 0);
    chk(r_err == 2'd2, "R5", "timeout code", int'(r_err), 2);
    chk(log_n == 16, "R5", "timeout poll count", log_n, 16);
    chk(r_rdata == 16'h0, "R10", "timeout read data", int'(r_rdata), 0);
    chk(r_lows == 15, "R6", "timeout idle cycles gap 0", r_lows, 15);

    // R5: busy clears on the 16th poll -> success
    run_op(0, 5'd4, 1, 0, 5'd3, 5'd2, 16'h0, 15, 0, 0, 0, 0, 0);
    chk(r_err == 2'd0, "R5", "16th poll clears", int'(r_err), 0);
    chk(log_n == 19, "R5", "16th poll access count", log_n, 19);

    // R11: each phase gets its own budget
    run_op(0, 5'd10, 1, 1, 5'd9, 5'd8, 16'h5A5A, 10, 10, 0, 0, 0, 0);
    chk(r_err == 2'd0, "R11", "two long polling phases", int'(r_err), 0);
    chk(log_n == 24, "R11", "two long phases access count", log_n, 24);

    // R7: error on the command write of a tunnelled read
    run_op(0, 5'd4, 1, 0, 5'd3, 5'd2, 16'h0, 0, 0, 0, 2, 0, 0);
    chk(r_err == 2'd1, "R7", "tunnel bus error code", int'(r_err), 1);
    repeat (5) @(negedge clk);
    chk(log_n == 2, "R7", "no access after error", log_n, 2);

    // R7: error on a direct read
    run_op(0, 5'd0, 0, 0, 5'd5, 5'd5, 16'h0, 0, 0, 0, 1, 0, 0);
    chk(r_err == 2'd1 && r_rdata == 16'h0, "R7", "direct bus error", int'(r_err), 1);

    // R8: response held under back-pressure
    run_op(0, 5'd0, 0, 0, 5'd12, 5'd7, 16'h0, 0, 0, 0, 0, 4, 0);
    chk(!r_hold_bad, "R8", "response stable while held", int'(r_hold_bad), 0);
    chk(r_rdata == pat(5'd12, 5'd7), "R10", "held read data", int'(r_rdata),
        int'(pat(5'd12, 5'd7)));

    // R8: request offered while busy is ignored
    run_op(1, 5'd2, 0, 0, 5'd6, 5'd3, 16'h0, 0, 0, 0, 0, 0, 1);
    repeat (6) @(negedge clk);
    chk(log_n == 1 && log_a[0] == 5'd8, "R8", "request while busy ignored", log_n, 1);
    chk(bus_req == 1'b0 && req_ready == 1'b1, "R8", "idle after ignored request",
        int'(bus_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule